// File: doc/BRIEF.md
# Strobe-Handshaked Word Queue

A first-in first-out buffer of 64 five-bit words whose two sides talk through pulses and ready flags rather than enables. A producer raises `shift_in` while `in_ready` is high to hand over the word on `in_data`. A consumer watches `out_ready`, takes the word already on `out_data`, and pulses `shift_out` to retire it. All logic runs on a single clock, and both strobes are sampled on that clock.

Each strobe pulse is acted on at most once. A `shift_in` held high against a full buffer stays pending. It is accepted in the first cycle that a location becomes free. A read drops `out_ready` for the length of the `shift_out` pulse. The next word is committed to `out_data` after the pulse ends. When the buffer runs dry, `out_data` keeps the last word read.

Top module: `hs_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `in_ready` = 1, `out_ready` = 0 and `out_data` = 0, with the buffer empty.
- R2: A word is stored in the first cycle in which `shift_in` is high, this pulse has not yet stored a word, and there is room. A pulse held high for many cycles stores exactly one word.
- R3: `in_ready` is 1 exactly when fewer than 64 words are stored. It goes 0 once the 64th word is accepted, and the occupancy never exceeds 64.
- R4: A `shift_in` that is held high while the buffer is full stores its word in the cycle in which a read frees a location.
- R5: A read starts at the first clock that sees `shift_out` high after it was low, provided `out_ready` is 1. In the cycle after that clock, `out_ready` is 0 and the read pointer has advanced.
- R6: After the clock that sees `shift_out` low again, the next clock loads the following word onto `out_data` and raises `out_ready`, provided a word remains.
- R7: When a read removes the only stored word, `out_ready` stays 0 and `out_data` keeps that word until a new word is written.
- R8: A `shift_out` pulse that begins while `out_ready` is 0 is ignored. It moves no pointer and consumes no word.
- R9: Words are read in the order they were written.
- R10: A write and a read in the same cycle leave the occupancy unchanged. In that cycle a write into a full buffer is accepted, and `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_in | input | 1 | Write strobe; one word per high pulse |
| in_data | input | 5 | Word to be written |
| in_ready | output | 1 | High while the buffer has room |
| shift_out | input | 1 | Read strobe; retires the word on `out_data` |
| out_ready | output | 1 | High while `out_data` holds an unread word |
| out_data | output | 5 | Oldest unread word, or the last word read once the buffer is empty |

## Verification
The bench builds the block with its default values: 64 words of 5 bits. At that size a complete fill fits easily within the run, so the bench can fill the buffer, make the write wait against a full buffer, and then drain every word with its order checked. The five-bit width lets the stored pattern repeat across the 64 entries without any two neighbours being equal. This makes a word that is skipped or duplicated visible when the buffer is drained.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  // Pointer step with wrap at the buffer depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of writes and reads.
  function automatic int unsigned occ_next(input int unsigned occ, input logic wr, input logic rd);
    return occ + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction
endpackage

// File: rtl/hsf_edge.sv
module hsf_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/hsf_store.sv
module hsf_store #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/hsf_rdctl.sv
module hsf_rdctl #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             so_rise,
  input  logic             so_fall,
  input  logic             occupied,
  input  logic [WIDTH-1:0] head_word,
  output logic             rd_fire,
  output logic             rd_busy,
  output logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign rd_fire = so_rise & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy   <= 1'b0;
      out_ready <= 1'b0;
      out_data  <= '0;
    end else if (rd_fire) begin
      rd_busy   <= 1'b1;
      out_ready <= 1'b0;
    end else if (rd_busy) begin
      if (so_fall) rd_busy <= 1'b0;
    end else if (occupied) begin
      out_data  <= head_word;
      out_ready <= 1'b1;
    end else begin
      out_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  import hsf_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             si_used;
  logic             wr_fire, rd_fire, rd_busy;
  logic             so_rise, so_fall;
  logic [WIDTH-1:0] head_word;

  hsf_edge u_so_edge (
    .clk(clk), .rst(rst), .level(shift_out), .rise(so_rise), .fall(so_fall)
  );

  hsf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(head_word)
  );

  hsf_rdctl #(.WIDTH(WIDTH)) u_rdctl (
    .clk(clk), .rst(rst), .so_rise(so_rise), .so_fall(so_fall),
    .occupied(count != '0), .head_word(head_word), .rd_fire(rd_fire),
    .rd_busy(rd_busy), .out_ready(out_ready), .out_data(out_data)
  );

  assign in_ready = (count != CW'(DEPTH));
  // One word per strobe pulse; a full buffer admits it only alongside a read.
  assign wr_fire  = shift_in & ~si_used & (in_ready | rd_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      si_used <= 1'b0;
    end else begin
      if (wr_fire)        si_used <= 1'b1;
      else if (!shift_in) si_used <= 1'b0;
      if (wr_fire) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (rd_fire) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      count <= CW'(occ_next(32'(count), wr_fire, rd_fire));
    end
  end
endmodule

// File: rtl/hs_fifo_chk.sv
module hs_fifo_chk #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic             so_rise,
  input logic [AW-1:0]    rd_ptr,
  input logic [CW-1:0]    count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3
  AST_FULL_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && wr_fire) |-> rd_fire); // R10
  AST_ONE_WORD_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire); // R2
  AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> !out_ready); // R5
  AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (rst)
    (so_rise && !out_ready) |=> $stable(rd_ptr)); // R8
  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> !out_ready); // R7
  AST_HEAD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !rd_fire) |=> $stable(out_data)); // R9
endmodule

bind hs_fifo hs_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_ready(out_ready),
  .out_data(out_data), .wr_fire(wr_fire), .rd_fire(rd_fire),
  .so_rise(so_rise), .rd_ptr(rd_ptr), .count(count)
);

// File: tb/hs_fifo_test.sv
module hs_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_in = 1'b0, shift_out = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_ready;
  logic [W-1:0] out_data;

  int errors = 0, checks = 0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .in_data(in_data),
    .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one write pulse; the expected item is queued when the model has room.
  task automatic push_word(input logic [W-1:0] d);
    @(negedge clk); in_data = d; shift_in = 1'b1;
    @(negedge clk); shift_in = 1'b0;
    if (exp_q.size() < D) exp_q.push_back(d);
  endtask

  task automatic wait_ready(input string req);
    for (int i = 0; i < 20 && !out_ready; i++) @(negedge clk);
    chk(req, out_ready, 1);
  endtask

  // Monitor side: compare the presented head with the queue front, then retire it.
  task automatic pop_word();
    logic [W-1:0] e;
    wait_ready("R6 ready before read");
    e = exp_q.pop_front();
    chk("R9 order", out_data, e);
    @(negedge clk); shift_out = 1'b1;
    @(negedge clk); chk("R5 ready low during strobe", out_ready, 0); shift_out = 1'b0;
    @(negedge clk); @(negedge clk);
    if (exp_q.size() > 0) chk("R6 next word ready", out_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_ready", out_ready, 0);
    chk("R1 out_data", out_data, 0);

    // R2/R9: three words, read back in order
    push_word(5'h0A); push_word(5'h0B); push_word(5'h0C);
    repeat (3) pop_word();
    repeat (4) @(negedge clk);
    chk("R7 ready stays low", out_ready, 0);
    chk("R7 last word kept", out_data, 5'h0C);

    // R8: strobe while empty is ignored
    @(negedge clk); shift_out = 1'b1;
    @(negedge clk); shift_out = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 data unchanged", out_data, 5'h0C);
    push_word(5'h11);
    pop_word();

    // R2: held strobe stores once
    @(negedge clk); in_data = 5'h15; shift_in = 1'b1;
    repeat (6) @(negedge clk);
    shift_in = 1'b0; exp_q.push_back(5'h15);
    push_word(5'h16);
    pop_word(); pop_word();
    repeat (4) @(negedge clk);
    chk("R2 no extra word", out_ready, 0);

    // R3: fill
    for (int i = 0; i < D; i++) begin
      if (i == D - 1) chk("R3 room before last", in_ready, 1);
      push_word(W'(i * 7 + 3));
    end
    chk("R3 full", in_ready, 0);

    // R4: pending write while full
    @(negedge clk); in_data = 5'h1F; shift_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 still full", in_ready, 0);
    pop_word();
    exp_q.push_back(5'h1F);
    shift_in = 1'b0;
    @(negedge clk);
    chk("R4 pending stored, full again", in_ready, 0);

    // R10: write and read together at full
    wait_ready("R10 ready");
    chk("R10 head", out_data, exp_q.pop_front());
    @(negedge clk); in_data = 5'h05; shift_in = 1'b1; shift_out = 1'b1;
    exp_q.push_back(5'h05);
    @(negedge clk); shift_in = 1'b0; shift_out = 1'b0;
    chk("R10 count unchanged at full", in_ready, 0);
    while (exp_q.size() > 0) pop_word();
    repeat (4) @(negedge clk);
    chk("R3 drained room", in_ready, 1);
    chk("R7 drained ready low", out_ready, 0);

    // R10: simultaneous below full
    push_word(5'h02); push_word(5'h03);
    wait_ready("R10 ready mid");
    chk("R10 head mid", out_data, exp_q.pop_front());
    @(negedge clk); in_data = 5'h04; shift_in = 1'b1; shift_out = 1'b1;
    exp_q.push_back(5'h04);
    @(negedge clk); shift_in = 1'b0; shift_out = 1'b0;
    pop_word(); pop_word();
    repeat (4) @(negedge clk);
    chk("R10 exactly two left", out_ready, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule